// File: doc/BRIEF.md
# Mode Command Descriptor Control

This block keeps one control word for each mode code of a serial-bus remote terminal. Each word has three bits the host may set: an access-interrupt enable, a broadcast-interrupt enable and a force-busy request. It also has two bits only the block maintains: a "touched" flag and a ping-pong buffer pointer. The bus front end drives the mode code of the command it is answering. In the same cycle the block returns whether the status reply must show Busy, whether the mode data word must be held back, and which data buffer (A or B) the message uses.

When the front end strobes the end of a message, the block updates the word for that mode code. It then raises a one-cycle interrupt together with a log entry (mode code and cause) if the enables allow it. The host reads and writes the words through a simple same-cycle port. A read clears the touched flag of the word it reads. A software reset clears the device-maintained bits of every word and leaves the host enables as they are.

Top module: `mode_desc_ctrl`

## Requirements
- R1: After master reset (`rst_n` low), every word reads 0, `buf_b` is 0 and `irq`/`log_vld` are low.
- R2: A host write to address N updates only the access enable (bit 14), broadcast enable (bit 13) and force-busy (bit 12) of word N. Data on bit 11 (touched) and bit 10 (pointer) is ignored. Every other read bit is 0.
- R3: A completion that is recognised and not illegal raises an access interrupt (log_kind bit 0) when the word's access enable and `gl_acc_ien` are both 1.
- R4: A recognised, not illegal broadcast completion raises a broadcast interrupt (log_kind bit 1) when the word's broadcast enable and `gl_bc_ien` are both 1. With `cfg_bc_off` high, broadcast completions are not recognised: they change no word and raise nothing.
- R5: `rsp_busy` is high for `cmd_code` when either `gl_busy` or that word's force-busy bit is 1.
- R6: For mode code 8, `rsp_busy` is always 0, whatever the force-busy bit or `gl_busy` say.
- R7: `mdata_sup` is high exactly when `rsp_busy` is high and `cmd_code` is 16 or above.
- R8: Any recognised completion sets the touched bit of its word. A host read of a word clears that bit. If the set and the clear land on the same word in the same cycle, the set wins.
- R9: With `cfg_pp` high, a recognised completion that is error-free (`done_ok`) and did not end with Busy (`done_busy` low) inverts the word's pointer bit. A completion that ended with Busy never inverts it.
- R10: With `cfg_hold` high, an illegal completion leaves the pointer unchanged. With `cfg_hold` low, an error-free, non-busy illegal completion inverts it.
- R11: `soft_rst` clears the touched and pointer bits of every word, overriding any completion in that cycle, and keeps the three host-set bits.
- R12: `buf_b` equals the pointer bit of the word for `cmd_code` when `cfg_pp` is high, and is 0 (buffer A) when `cfg_pp` is low.
- R13: `irq` and `log_vld` pulse for one cycle, the cycle after the completion strobe. `log_code` gives the mode code and `log_kind` gives the causes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Master reset, active low, asynchronous |
| soft_rst | input | 1 | Software reset of device-maintained bits |
| cmd_code | input | 5 | Mode code of the command being answered |
| rsp_busy | output | 1 | Status reply shall show Busy |
| mdata_sup | output | 1 | Suppress the mode data word |
| buf_b | output | 1 | 1 selects buffer B, 0 buffer A |
| done_stb | input | 1 | Message-complete strobe |
| done_code | input | 5 | Mode code of the completed message |
| done_bcast | input | 1 | Completed command was broadcast |
| done_ok | input | 1 | Message was error-free |
| done_illegal | input | 1 | Command was illegal |
| done_busy | input | 1 | Message ended with Busy status |
| gl_acc_ien | input | 1 | Global access-interrupt enable |
| gl_bc_ien | input | 1 | Global broadcast-interrupt enable |
| gl_busy | input | 1 | Global Busy for all valid commands |
| cfg_bc_off | input | 1 | Broadcast treated as invalid |
| cfg_hold | input | 1 | Keep pointer after illegal messages |
| cfg_pp | input | 1 | Ping-pong buffer mode |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 5 | Word index for host access |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Word at host_addr |
| irq | output | 1 | Interrupt request pulse |
| log_vld | output | 1 | Log entry valid |
| log_code | output | 5 | Mode code of the log entry |
| log_kind | output | 2 | Bit 0 access, bit 1 broadcast |

## Verification
`rsp_busy`, `mdata_sup`, `buf_b` and `host_rdata` are combinational from the current inputs and the stored words, so they are due in the same cycle the inputs are applied. Word updates from writes, reads, completions and software reset show after the next rising edge. `irq` and the log fields appear one edge after the completion strobe and last one cycle. The bench changes inputs just after each rising edge, advances its model on the edge, and compares every output on the falling edge. Each value is therefore checked in the cycle it is due.

// File: rtl/mcd_pkg.sv
package mcd_pkg;

   // Per mode code descriptor state: three host bits, two device bits
   typedef struct packed {
      logic acc_en;
      logic bc_en;
      logic busy_req;
      logic touched;
      logic ptr_b;
   } desc_t;

   // Interrupt cause of one completion
   typedef struct packed {
      logic bc_hit;
      logic acc_hit;
   } irq_kind_t;

endpackage

// File: rtl/mcd_word_bank.sv
module mcd_word_bank
   import mcd_pkg::*;
#(
   parameter int NUM_CODES = 32,
   localparam int CODE_W = $clog2(NUM_CODES)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      soft_rst,
   input  logic                      host_wr,
   input  logic                      host_rd,
   input  logic [CODE_W-1:0]         host_addr,
   input  logic [2:0]                wr_fields,
   input  logic                      evt_touch,
   input  logic                      evt_flip,
   input  logic [CODE_W-1:0]         evt_code,
   output desc_t [NUM_CODES-1:0]     desc_q
);

   for (genvar g = 0; g < NUM_CODES; g++) begin : g_ent
      localparam logic [CODE_W-1:0] IDX = CODE_W'(g);
      desc_t ent_q;
      logic  hit_wr, hit_rd, hit_evt, hit_flip;

      assign hit_wr   = host_wr   && (host_addr == IDX);
      assign hit_rd   = host_rd   && (host_addr == IDX);
      assign hit_evt  = evt_touch && (evt_code  == IDX);
      assign hit_flip = evt_flip  && (evt_code  == IDX);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ent_q <= '0;
         end else begin
            if (hit_wr) begin
               ent_q.acc_en   <= wr_fields[2];
               ent_q.bc_en    <= wr_fields[1];
               ent_q.busy_req <= wr_fields[0];
            end
            if (soft_rst) begin
               ent_q.touched <= 1'b0;
               ent_q.ptr_b   <= 1'b0;
            end else begin
               // completion set has priority over read clear
               if (hit_evt)
                  ent_q.touched <= 1'b1;
               else if (hit_rd)
                  ent_q.touched <= 1'b0;
               if (hit_flip)
                  ent_q.ptr_b <= ~ent_q.ptr_b;
            end
         end
      end

      assign desc_q[g] = ent_q;
   end

endmodule

// File: rtl/mcd_evt_decode.sv
module mcd_evt_decode
   import mcd_pkg::*;
(
   input  logic      done_stb,
   input  logic      done_bcast,
   input  logic      done_ok,
   input  logic      done_illegal,
   input  logic      done_busy,
   input  logic      sel_acc_en,
   input  logic      sel_bc_en,
   input  logic      gl_acc_ien,
   input  logic      gl_bc_ien,
   input  logic      cfg_bc_off,
   input  logic      cfg_hold,
   input  logic      cfg_pp,
   output logic      evt_touch,
   output logic      evt_flip,
   output irq_kind_t evt_kind
);

   logic recog;
   logic legal;
   logic clean;

   // broadcast commands are not recognised when broadcast is disabled
   assign recog = done_stb && !(done_bcast && cfg_bc_off);
   assign legal = recog && !done_illegal;
   // error-free, not busy, and not an illegal one that must be held
   assign clean = done_ok && !done_busy && !(cfg_hold && done_illegal);

   assign evt_touch        = recog;
   assign evt_flip         = recog && cfg_pp && clean;
   assign evt_kind.acc_hit = legal && sel_acc_en && gl_acc_ien;
   assign evt_kind.bc_hit  = legal && done_bcast && sel_bc_en && gl_bc_ien;

endmodule

// File: rtl/mcd_rsp_ctrl.sv
module mcd_rsp_ctrl #(
   parameter int CODE_W             = 5,
   parameter int RESET_CODE         = 8,
   parameter int DATA_CODE_MIN      = 16,
   parameter bit RESET_INHIBITS_ALL = 1'b1
) (
   input  logic [CODE_W-1:0] cmd_code,
   input  logic              sel_busy_req,
   input  logic              sel_ptr_b,
   input  logic              gl_busy,
   input  logic              cfg_pp,
   output logic              rsp_busy,
   output logic              mdata_sup,
   output logic              buf_b
);

   logic is_reset;
   logic is_data;

   assign is_reset = (cmd_code == CODE_W'(RESET_CODE));
   assign is_data  = (cmd_code >= CODE_W'(DATA_CODE_MIN));

   if (RESET_INHIBITS_ALL) begin : g_inhibit_all
      // reset mode code never replies Busy
      assign rsp_busy = (gl_busy || sel_busy_req) && !is_reset;
   end else begin : g_inhibit_own
      // reset mode code ignores only its own busy request
      assign rsp_busy = gl_busy || (sel_busy_req && !is_reset);
   end

   assign mdata_sup = rsp_busy && is_data;
   assign buf_b     = cfg_pp && sel_ptr_b;

endmodule

// File: rtl/mcd_irq_log.sv
module mcd_irq_log
   import mcd_pkg::*;
#(
   parameter int CODE_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  irq_kind_t         evt_kind,
   input  logic [CODE_W-1:0] evt_code,
   output logic              log_vld,
   output logic [CODE_W-1:0] log_code,
   output logic [1:0]        log_kind
);

   logic fire;
   assign fire = evt_kind.acc_hit || evt_kind.bc_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         log_vld  <= 1'b0;
         log_code <= '0;
         log_kind <= '0;
      end else begin
         log_vld <= fire;
         if (fire) begin
            log_code <= evt_code;
            log_kind <= evt_kind;
         end
      end
   end

endmodule

// File: rtl/mode_desc_ctrl.sv
module mode_desc_ctrl
   import mcd_pkg::*;
#(
   parameter int NUM_CODES          = 32,
   parameter int WORD_W             = 16,
   parameter int POS_ACC            = 14,
   parameter int POS_BC             = 13,
   parameter int POS_BUSY           = 12,
   parameter int POS_TOUCH          = 11,
   parameter int POS_PTR            = 10,
   parameter int RESET_CODE         = 8,
   parameter int DATA_CODE_MIN      = 16,
   parameter bit RESET_INHIBITS_ALL = 1'b1,
   localparam int CODE_W = $clog2(NUM_CODES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_rst,
   input  logic [CODE_W-1:0] cmd_code,
   output logic              rsp_busy,
   output logic              mdata_sup,
   output logic              buf_b,
   input  logic              done_stb,
   input  logic [CODE_W-1:0] done_code,
   input  logic              done_bcast,
   input  logic              done_ok,
   input  logic              done_illegal,
   input  logic              done_busy,
   input  logic              gl_acc_ien,
   input  logic              gl_bc_ien,
   input  logic              gl_busy,
   input  logic              cfg_bc_off,
   input  logic              cfg_hold,
   input  logic              cfg_pp,
   input  logic              host_rd,
   input  logic              host_wr,
   input  logic [CODE_W-1:0] host_addr,
   input  logic [WORD_W-1:0] host_wdata,
   output logic [WORD_W-1:0] host_rdata,
   output logic              irq,
   output logic              log_vld,
   output logic [CODE_W-1:0] log_code,
   output logic [1:0]        log_kind
);

   // elaboration-time parameter checks
   if ((NUM_CODES < 2) || ((NUM_CODES & (NUM_CODES - 1)) != 0)) begin : g_bad_codes
      $error("NUM_CODES must be a power of two of at least 2");
   end
   if ((POS_ACC >= WORD_W) || (POS_BC >= WORD_W) || (POS_BUSY >= WORD_W) ||
       (POS_TOUCH >= WORD_W) || (POS_PTR >= WORD_W)) begin : g_bad_pos
      $error("field position outside the word");
   end
   if ((RESET_CODE >= NUM_CODES) || (DATA_CODE_MIN >= NUM_CODES)) begin : g_bad_mc
      $error("mode code parameter outside the code range");
   end

   desc_t [NUM_CODES-1:0] desc_q;
   desc_t                 done_d, cmd_d, host_d;
   logic  [2:0]           wr_fields;
   logic                  evt_touch, evt_flip;
   irq_kind_t             evt_kind;

   assign wr_fields = {host_wdata[POS_ACC], host_wdata[POS_BC], host_wdata[POS_BUSY]};
   assign done_d    = desc_q[done_code];
   assign cmd_d     = desc_q[cmd_code];
   assign host_d    = desc_q[host_addr];

   mcd_word_bank #(
      .NUM_CODES (NUM_CODES)
   ) bank_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .soft_rst  (soft_rst),
      .host_wr   (host_wr),
      .host_rd   (host_rd),
      .host_addr (host_addr),
      .wr_fields (wr_fields),
      .evt_touch (evt_touch),
      .evt_flip  (evt_flip),
      .evt_code  (done_code),
      .desc_q    (desc_q)
   );

   mcd_evt_decode dec_i (
      .done_stb     (done_stb),
      .done_bcast   (done_bcast),
      .done_ok      (done_ok),
      .done_illegal (done_illegal),
      .done_busy    (done_busy),
      .sel_acc_en   (done_d.acc_en),
      .sel_bc_en    (done_d.bc_en),
      .gl_acc_ien   (gl_acc_ien),
      .gl_bc_ien    (gl_bc_ien),
      .cfg_bc_off   (cfg_bc_off),
      .cfg_hold     (cfg_hold),
      .cfg_pp       (cfg_pp),
      .evt_touch    (evt_touch),
      .evt_flip     (evt_flip),
      .evt_kind     (evt_kind)
   );

   mcd_rsp_ctrl #(
      .CODE_W             (CODE_W),
      .RESET_CODE         (RESET_CODE),
      .DATA_CODE_MIN      (DATA_CODE_MIN),
      .RESET_INHIBITS_ALL (RESET_INHIBITS_ALL)
   ) rsp_i (
      .cmd_code     (cmd_code),
      .sel_busy_req (cmd_d.busy_req),
      .sel_ptr_b    (cmd_d.ptr_b),
      .gl_busy      (gl_busy),
      .cfg_pp       (cfg_pp),
      .rsp_busy     (rsp_busy),
      .mdata_sup    (mdata_sup),
      .buf_b        (buf_b)
   );

   mcd_irq_log #(
      .CODE_W (CODE_W)
   ) log_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt_kind (evt_kind),
      .evt_code (done_code),
      .log_vld  (log_vld),
      .log_code (log_code),
      .log_kind (log_kind)
   );

   assign irq = log_vld;

   always_comb begin
      host_rdata            = '0;
      host_rdata[POS_ACC]   = host_d.acc_en;
      host_rdata[POS_BC]    = host_d.bc_en;
      host_rdata[POS_BUSY]  = host_d.busy_req;
      host_rdata[POS_TOUCH] = host_d.touched;
      host_rdata[POS_PTR]   = host_d.ptr_b;
   end

endmodule

// File: rtl/mcd_chk.sv
module mcd_chk #(
   parameter int CODE_W             = 5,
   parameter int WORD_W             = 16,
   parameter int POS_ACC            = 14,
   parameter int POS_BC             = 13,
   parameter int POS_BUSY           = 12,
   parameter int RESET_CODE         = 8,
   parameter int DATA_CODE_MIN      = 16,
   parameter bit RESET_INHIBITS_ALL = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [CODE_W-1:0] cmd_code,
   input logic              rsp_busy,
   input logic              mdata_sup,
   input logic              buf_b,
   input logic              cfg_pp,
   input logic              done_stb,
   input logic              done_bcast,
   input logic              done_illegal,
   input logic              cfg_bc_off,
   input logic              log_vld,
   input logic [1:0]        log_kind,
   input logic              host_wr,
   input logic [CODE_W-1:0] host_addr,
   input logic [WORD_W-1:0] host_wdata,
   input logic [WORD_W-1:0] host_rdata
);

   localparam logic [WORD_W-1:0] WR_MASK =
      (WORD_W'(1) << POS_ACC) | (WORD_W'(1) << POS_BC) | (WORD_W'(1) << POS_BUSY);

   // R2: written host bits read back on the same address the next cycle
   p_wr_readback_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(host_wr) && $past(rst_n) && (host_addr == $past(host_addr)))
      |-> ((host_rdata & WR_MASK) == ($past(host_wdata) & WR_MASK)));

   // R3: an interrupt follows a legal completion strobe
   p_irq_after_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
      log_vld |-> $past(done_stb && !done_illegal));

   // R4: broadcast cause only for recognised broadcast completions
   p_bc_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (log_vld && log_kind[1]) |-> $past(done_bcast && !cfg_bc_off));

   // R6: reset mode code never answers Busy
   if (RESET_INHIBITS_ALL) begin : g_r6
      p_no_busy_reset_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (cmd_code == CODE_W'(RESET_CODE)) |-> !rsp_busy);
   end

   // R7: data suppression only with Busy on a data-carrying code
   p_sup_needs_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      mdata_sup |-> (rsp_busy && (cmd_code >= CODE_W'(DATA_CODE_MIN))));

   // R12: single-buffer mode always uses buffer A
   p_single_buf_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_pp |-> !buf_b);

   // R13: a log entry always carries at least one cause
   p_log_cause_r13: assert property (@(posedge clk) disable iff (!rst_n)
      log_vld |-> (log_kind != 2'b00));

endmodule

bind mode_desc_ctrl mcd_chk #(
   .CODE_W             (CODE_W),
   .WORD_W             (WORD_W),
   .POS_ACC            (POS_ACC),
   .POS_BC             (POS_BC),
   .POS_BUSY           (POS_BUSY),
   .RESET_CODE         (RESET_CODE),
   .DATA_CODE_MIN      (DATA_CODE_MIN),
   .RESET_INHIBITS_ALL (RESET_INHIBITS_ALL)
) chk_i (.*);

// File: tb/mode_desc_ctrl_tb_top.sv
`timescale 1ns/1ps
module mode_desc_ctrl_tb_top;

   localparam int N  = 32;
   localparam int CW = 5;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic rst_n = 1'b0, soft_rst = 1'b0;
   logic [CW-1:0] cmd_code = '0, done_code = '0, host_addr = '0;
   logic done_stb = 0, done_bcast = 0, done_ok = 0, done_illegal = 0, done_busy = 0;
   logic gl_acc_ien = 0, gl_bc_ien = 0, gl_busy = 0;
   logic cfg_bc_off = 0, cfg_hold = 0, cfg_pp = 0;
   logic host_rd = 0, host_wr = 0;
   logic [15:0] host_wdata = '0;
   logic rsp_busy, mdata_sup, buf_b, irq, log_vld;
   logic [15:0] host_rdata;
   logic [CW-1:0] log_code;
   logic [1:0] log_kind;

   mode_desc_ctrl dut_i (.*);

   int n_vec = 0, n_bad = 0;
   bit finished = 0;

   // reference model state
   bit m_acc[N], m_bc[N], m_busy[N], m_touch[N], m_ptr[N];
   bit m_lv;
   int m_lcode, m_lkind;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < N; i++) begin
            m_acc[i] = 0; m_bc[i] = 0; m_busy[i] = 0; m_touch[i] = 0; m_ptr[i] = 0;
         end
         m_lv = 0; m_lcode = 0; m_lkind = 0;
      end else begin
         bit rec, legal, a, b, fl;
         rec   = done_stb && !(done_bcast && cfg_bc_off);
         legal = rec && !done_illegal;
         a     = legal && m_acc[done_code] && gl_acc_ien;
         b     = legal && done_bcast && m_bc[done_code] && gl_bc_ien;
         fl    = rec && cfg_pp && done_ok && !done_busy && !(cfg_hold && done_illegal);
         m_lv  = a || b;
         if (a || b) begin
            m_lcode = int'(done_code);
            m_lkind = (b ? 2 : 0) + (a ? 1 : 0);
         end
         if (soft_rst) begin
            for (int i = 0; i < N; i++) begin m_touch[i] = 0; m_ptr[i] = 0; end
         end else begin
            if (host_rd) m_touch[host_addr] = 0;
            if (rec) m_touch[done_code] = 1;
            if (fl) m_ptr[done_code] = !m_ptr[done_code];
         end
         if (host_wr) begin
            m_acc[host_addr]  = host_wdata[14];
            m_bc[host_addr]   = host_wdata[13];
            m_busy[host_addr] = host_wdata[12];
         end
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // compare on every falling edge
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         logic [15:0] e_rd;
         bit e_busy;
         e_rd = '0;
         e_rd[14] = m_acc[host_addr]; e_rd[13] = m_bc[host_addr];
         e_rd[12] = m_busy[host_addr]; e_rd[11] = m_touch[host_addr];
         e_rd[10] = m_ptr[host_addr];
         e_busy = (cmd_code != 5'd8) && (gl_busy || m_busy[cmd_code]);
         chk("R1 R2 R8 R9 R10 R11 host word", 32'(host_rdata), 32'(e_rd));
         chk("R5 R6 busy reply", 32'(rsp_busy), 32'(e_busy));
         chk("R7 data suppress", 32'(mdata_sup), 32'(e_busy && (cmd_code >= 5'd16)));
         chk("R12 buffer select", 32'(buf_b), 32'(cfg_pp && m_ptr[cmd_code]));
         chk("R3 R4 R13 irq", 32'(irq), 32'(m_lv));
         chk("R13 log valid", 32'(log_vld), 32'(m_lv));
         if (m_lv) begin
            chk("R13 log code", 32'(log_code), 32'(m_lcode));
            chk("R3 R4 log kind", 32'(log_kind), 32'(m_lkind));
         end
      end
   end

   task automatic step();
      @(posedge clk);
      #1;
      done_stb = 0; host_wr = 0; host_rd = 0; soft_rst = 0;
   endtask

   task automatic wr(input int a, input logic [15:0] d);
      host_wr = 1; host_addr = CW'(a); host_wdata = d; step();
   endtask

   task automatic rd(input int a);
      host_rd = 1; host_addr = CW'(a); step();
   endtask

   task automatic done(input int c, input bit bc, input bit ok, input bit ill, input bit bsy);
      done_stb = 1; done_code = CW'(c); done_bcast = bc; done_ok = ok;
      done_illegal = ill; done_busy = bsy; step();
   endtask

   // watchdog
   initial begin
      #(5.0 * 200000);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         finished = 1;
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      step(); step();                         // R1 idle after reset
      gl_acc_ien = 1; gl_bc_ien = 1; cfg_pp = 1;
      wr(3, 16'hFFFF); rd(3);                 // R2 status bits ignored
      wr(17, 16'h1000); wr(8, 16'h1000); wr(20, 16'h6C00);
      cmd_code = 5'd17; step();               // R5 R7 own busy, data code
      cmd_code = 5'd8;  step();               // R6 reset code
      gl_busy = 1; step(); cmd_code = 5'd5; step(); cmd_code = 5'd16; step();
      gl_busy = 0;
      cmd_code = 5'd3;
      done(3, 0, 1, 0, 0); step();            // R3 R9 R13
      done(3, 1, 1, 0, 0); step();            // R4 both causes
      cfg_bc_off = 1; done(3, 1, 1, 0, 0); step(); cfg_bc_off = 0;  // R4 ignored
      done(3, 0, 1, 0, 1); step();            // R9 busy holds pointer
      cfg_hold = 1; done(3, 0, 1, 1, 0); step();  // R10 hold
      cfg_hold = 0; done(3, 0, 1, 1, 0); step();  // R10 toggles
      host_rd = 1; host_addr = 5'd3; done(3, 0, 1, 0, 0); step(); // R8 set wins
      rd(3); host_addr = 5'd3; step();
      done(20, 0, 1, 0, 0); soft_rst = 1; step(); // R11
      host_addr = 5'd20; step(); host_addr = 5'd3; step();
      cfg_pp = 0; step();                     // R12 single buffer
      // random phase
      for (int i = 0; i < 4000; i++) begin
         cmd_code  = CW'($urandom);
         host_addr = CW'($urandom);
         host_wdata = 16'($urandom);
         host_wr   = ($urandom % 4) == 0;
         host_rd   = ($urandom % 4) == 0;
         done_stb  = ($urandom % 3) == 0;
         done_code = ($urandom % 2) ? cmd_code : CW'($urandom);
         done_bcast = ($urandom % 3) == 0;
         done_ok   = ($urandom % 5) != 0;
         done_illegal = ($urandom % 6) == 0;
         done_busy = ($urandom % 6) == 0;
         soft_rst  = ($urandom % 97) == 0;
         if (($urandom % 50) == 0) begin
            gl_acc_ien = 1'($urandom); gl_bc_ien = 1'($urandom); gl_busy = 1'($urandom);
            cfg_bc_off = 1'($urandom); cfg_hold = 1'($urandom); cfg_pp = 1'($urandom);
         end
         @(posedge clk); #1;
      end
      done_stb = 0; host_wr = 0; host_rd = 0; soft_rst = 0;
      step(); step();
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule